// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Timer

This block is a watchdog that counts down in two consecutive stages, each stage length taken from its own 20-bit preload register. When the first stage runs out, the block issues a one-cycle interrupt of a selectable kind and moves straight into the second stage. When the second stage runs out, the block may request a system reset and record that event in a sticky flag. If reset is not requested, it may instead start the first stage again.

The preload value is widened by a left shift before counting. The shift amount depends on a scale select: one setting gives a coarse tick and the other a fine tick. Software keeps the system alive by pulsing a reload input, which starts the first stage over. The register access path and the interrupt controller are not part of this block. They connect through plain inputs (control levels, a preload write port, strobes) and outputs (pulses, stage, flag).

Top module: `wdog_two_stage`

## Requirements
- R1: After `rst_n` is released, `stage` reads 0 (idle), `irqPulse`, `smiPulse` and `resetReq` are low, and both preload registers hold 0xFFFFF. After `porRst_n` is released, `prevReboot` is low.
- R2: Stage length in clock cycles is N = preload << 15 when `fastScale` is 0 and N = preload << 5 when `fastScale` is 1. If the clock edge that starts stage one is edge E, the stage-one expiry outputs appear after edge E+N+1. If the second preload gives M, the stage-two expiry outputs appear after edge E+N+M+2.
- R3: Counting starts, with `stage` = 1, only on a 0-to-1 change of `enable`. While `enable` is low, `stage` is 0 one edge later and no expiry outputs occur.
- R4: A `reload` pulse while the watchdog is armed restarts stage one from the first preload, and the stage-one expiry follows N+1 edges after the reload edge. A `reload` while disarmed leaves `stage` at 0.
- R5: At stage-one expiry, `stage` becomes 2 and the second preload is loaded. `intType` decides the pulse: 0 gives a one-cycle `irqPulse`, 2 gives a one-cycle `smiPulse`, and 1 or 3 give no pulse.
- R6: At stage-two expiry with `rebootEn` high, the block does all of the following:
  - pulses `resetReq` for one cycle;
  - sets `prevReboot`;
  - returns `stage` to 0;
  - restores both preloads to 0xFFFFF;
  - disarms itself, so `reload` is ignored and a new rising edge of `enable` is needed.

  This takes precedence over free-run.
- R7: At stage-two expiry with `rebootEn` low, `stage` returns to 1 and counting restarts from the first preload when `freeRun` is high. When `freeRun` is low, `stage` returns to 0. In neither case does `resetReq` pulse.
- R8: `prevReboot` is unaffected by `rst_n`. It is cleared only by `flagClear` or by `porRst_n`.
- R9: A `preloadWr` pulse writes `preloadData` into the first preload when `preloadSel` is 0 and into the second when it is 1. The new value takes effect at the next load and does not change a stage already counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock; one count tick per cycle |
| rst_n | input | 1 | Active-low block reset |
| porRst_n | input | 1 | Active-low power-on reset for the sticky flag only |
| enable | input | 1 | Watchdog enable level; rising edge arms and starts |
| reload | input | 1 | Keep-alive strobe |
| freeRun | input | 1 | Restart stage one after stage-two expiry |
| rebootEn | input | 1 | Request reset on stage-two expiry |
| fastScale | input | 1 | 1 selects shift 5, 0 selects shift 15 |
| intType | input | 2 | Stage-one interrupt kind (0 normal, 2 SMI, 1/3 none) |
| flagClear | input | 1 | Clears the sticky reboot flag |
| preloadWr | input | 1 | Preload write strobe |
| preloadSel | input | 1 | Preload select: 0 first, 1 second |
| preloadData | input | 20 | Preload write value |
| irqPulse | output | 1 | One-cycle normal interrupt at stage-one expiry |
| smiPulse | output | 1 | One-cycle SMI at stage-one expiry |
| resetReq | output | 1 | One-cycle system reset request |
| stage | output | 2 | 0 idle, 1 stage one, 2 stage two |
| prevReboot | output | 1 | Sticky flag: the last reset came from this watchdog |

## Verification
The bench measures the exact edge of each expiry against the shifted preload in both scales. This includes a zero preload, which must expire one edge after loading; an off-by-one load or compare would move every pulse by a cycle.

It checks that after a watchdog reset a held-high `enable` and a `reload` pulse both fail to restart the count. It also checks that the restored preload no longer gives a short timeout. A design that forgot to disarm or to restore would fire again within a few hundred cycles.

It checks that a preload write in the middle of a stage leaves that stage's timing alone, and that the sticky flag survives the block reset. A design that reset the flag with `rst_n` would lose the record of a watchdog-caused reboot.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    STG_IDLE = 2'd0,
    STG_ONE  = 2'd1,
    STG_TWO  = 2'd2
  } stage_e;

  localparam logic [1:0] INT_NORMAL = 2'd0;
  localparam logic [1:0] INT_SMI    = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
    logic run;
    logic restore;
  } dpCtrl_t;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int PRELOAD_W  = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  dpCtrl_t              ctl,
  input  logic                 fastScale,
  input  logic                 preloadWr,
  input  logic                 preloadSel,
  input  logic [PRELOAD_W-1:0] preloadData,
  output logic                 countZero
);

  localparam int MAX_SHIFT  = (SLOW_SHIFT > FAST_SHIFT) ? SLOW_SHIFT : FAST_SHIFT;
  localparam int CNT_W      = PRELOAD_W + MAX_SHIFT;
  localparam int NUM_STAGES = 2;

  logic [PRELOAD_W-1:0] preloadQ [NUM_STAGES];
  logic [CNT_W-1:0]     countQ;

  // one preload register per stage
  for (genvar g = 0; g < NUM_STAGES; g++) begin : gPreload
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        preloadQ[g] <= '1;
      end else if (ctl.restore) begin
        preloadQ[g] <= '1;
      end else if (preloadWr && (32'(preloadSel) == g)) begin
        preloadQ[g] <= preloadData;
      end
    end
  end

  function automatic logic [CNT_W-1:0] scaleUp(input logic [PRELOAD_W-1:0] v,
                                               input logic fast);
    logic [CNT_W-1:0] wide;
    wide = CNT_W'(v);
    return fast ? (wide << FAST_SHIFT) : (wide << SLOW_SHIFT);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countQ <= '0;
    end else if (ctl.loadFirst) begin
      countQ <= scaleUp(preloadQ[0], fastScale);
    end else if (ctl.loadSecond) begin
      countQ <= scaleUp(preloadQ[1], fastScale);
    end else if (ctl.run && (countQ != '0)) begin
      countQ <= countQ - 1'b1;
    end
  end

  assign countZero = (countQ == '0);

  // a nonzero first preload must never give an immediate expiry (R2)
  p_load_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.loadFirst && (preloadQ[0] != '0)) |=> !countZero);

  // watchdog reset puts both preloads back to all ones (R6)
  p_restore_defaults_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.restore |=> ((preloadQ[0] == '1) && (preloadQ[1] == '1)));

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       porRst_n,
  input  logic       enable,
  input  logic       reload,
  input  logic       freeRun,
  input  logic       rebootEn,
  input  logic [1:0] intType,
  input  logic       flagClear,
  input  logic       countZero,
  output dpCtrl_t    ctl,
  output logic [1:0] stage,
  output logic       irqPulse,
  output logic       smiPulse,
  output logic       resetReq,
  output logic       prevReboot
);

  stage_e stageQ, stageD;
  logic   armedQ, armedD;
  logic   enablePrevQ;
  logic   irqD, smiD, rstD, setFlag;
  logic   enRise, expire;

  assign enRise = enable && !enablePrevQ;
  assign expire = (stageQ != STG_IDLE) && countZero;

  always_comb begin
    stageD         = stageQ;
    armedD         = armedQ;
    ctl.loadFirst  = 1'b0;
    ctl.loadSecond = 1'b0;
    ctl.restore    = 1'b0;
    ctl.run        = (stageQ != STG_IDLE);
    irqD           = 1'b0;
    smiD           = 1'b0;
    rstD           = 1'b0;
    setFlag        = 1'b0;
    if (!enable) begin
      stageD = STG_IDLE;
      armedD = 1'b0;
    end else if (enRise) begin
      armedD        = 1'b1;
      stageD        = STG_ONE;
      ctl.loadFirst = 1'b1;
    end else if (armedQ && reload) begin
      stageD        = STG_ONE;
      ctl.loadFirst = 1'b1;
    end else if (expire) begin
      if (stageQ == STG_ONE) begin
        stageD         = STG_TWO;
        ctl.loadSecond = 1'b1;
        irqD           = (intType == INT_NORMAL);
        smiD           = (intType == INT_SMI);
      end else if (rebootEn) begin
        rstD        = 1'b1;
        setFlag     = 1'b1;
        ctl.restore = 1'b1;
        armedD      = 1'b0;
        stageD      = STG_IDLE;
      end else if (freeRun) begin
        stageD        = STG_ONE;
        ctl.loadFirst = 1'b1;
      end else begin
        stageD = STG_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stageQ      <= STG_IDLE;
      armedQ      <= 1'b0;
      enablePrevQ <= 1'b0;
      irqPulse    <= 1'b0;
      smiPulse    <= 1'b0;
      resetReq    <= 1'b0;
    end else begin
      stageQ      <= stageD;
      armedQ      <= armedD;
      enablePrevQ <= enable;
      irqPulse    <= irqD;
      smiPulse    <= smiD;
      resetReq    <= rstD;
    end
  end

  // sticky flag lives on the power-on reset only
  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      prevReboot <= 1'b0;
    end else if (setFlag) begin
      prevReboot <= 1'b1;
    end else if (flagClear) begin
      prevReboot <= 1'b0;
    end
  end

  assign stage = stageQ;

  p_stop_when_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (stage == 2'd0));

  p_int_enters_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irqPulse || smiPulse) |-> (stage == 2'd2));

  p_pulses_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irqPulse, smiPulse, resetReq}));

  p_reset_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n || !porRst_n)
    resetReq |-> (prevReboot && (stage == 2'd0)));

  p_reset_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    resetReq |=> !resetReq);

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
  import wdog_pkg::*;
#(
  parameter int PRELOAD_W  = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 porRst_n,
  input  logic                 enable,
  input  logic                 reload,
  input  logic                 freeRun,
  input  logic                 rebootEn,
  input  logic                 fastScale,
  input  logic [1:0]           intType,
  input  logic                 flagClear,
  input  logic                 preloadWr,
  input  logic                 preloadSel,
  input  logic [PRELOAD_W-1:0] preloadData,
  output logic                 irqPulse,
  output logic                 smiPulse,
  output logic                 resetReq,
  output logic [1:0]           stage,
  output logic                 prevReboot
);

  dpCtrl_t ctl;
  logic    countZero;

  wdog_ctrl uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .porRst_n   (porRst_n),
    .enable     (enable),
    .reload     (reload),
    .freeRun    (freeRun),
    .rebootEn   (rebootEn),
    .intType    (intType),
    .flagClear  (flagClear),
    .countZero  (countZero),
    .ctl        (ctl),
    .stage      (stage),
    .irqPulse   (irqPulse),
    .smiPulse   (smiPulse),
    .resetReq   (resetReq),
    .prevReboot (prevReboot)
  );

  wdog_datapath #(
    .PRELOAD_W  (PRELOAD_W),
    .SLOW_SHIFT (SLOW_SHIFT),
    .FAST_SHIFT (FAST_SHIFT)
  ) uDatapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .fastScale   (fastScale),
    .preloadWr   (preloadWr),
    .preloadSel  (preloadSel),
    .preloadData (preloadData),
    .countZero   (countZero)
  );

endmodule

// File: tb/wdog_two_stage_test.sv
module wdog_two_stage_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;
  localparam int NUM_VECS = 6;

  typedef struct packed {
    logic [19:0] pre1;
    logic [19:0] pre2;
    logic        fast;
    logic [1:0]  itype;
    logic        reboot;
    logic        free;
  } vec_t;

  localparam vec_t VECS [NUM_VECS] = '{
    '{pre1: 20'd3, pre2: 20'd2, fast: 1'b1, itype: 2'd0, reboot: 1'b1, free: 1'b0},
    '{pre1: 20'd1, pre2: 20'd4, fast: 1'b1, itype: 2'd2, reboot: 1'b0, free: 1'b1},
    '{pre1: 20'd0, pre2: 20'd0, fast: 1'b1, itype: 2'd3, reboot: 1'b0, free: 1'b0},
    '{pre1: 20'd2, pre2: 20'd1, fast: 1'b1, itype: 2'd1, reboot: 1'b1, free: 1'b1},
    '{pre1: 20'd1, pre2: 20'd0, fast: 1'b0, itype: 2'd0, reboot: 1'b0, free: 1'b0},
    '{pre1: 20'd5, pre2: 20'd3, fast: 1'b1, itype: 2'd2, reboot: 1'b1, free: 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0, porRst_n = 1'b0;
  logic enable = 1'b0, reload = 1'b0, freeRun = 1'b0, rebootEn = 1'b0;
  logic fastScale = 1'b1, flagClear = 1'b0, preloadWr = 1'b0, preloadSel = 1'b0;
  logic [1:0] intType = 2'd0;
  logic [19:0] preloadData = '0;
  logic irqPulse, smiPulse, resetReq, prevReboot;
  logic [1:0] stage;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  wdog_two_stage uut (
    .clk(clk), .rst_n(rst_n), .porRst_n(porRst_n), .enable(enable),
    .reload(reload), .freeRun(freeRun), .rebootEn(rebootEn),
    .fastScale(fastScale), .intType(intType), .flagClear(flagClear),
    .preloadWr(preloadWr), .preloadSel(preloadSel), .preloadData(preloadData),
    .irqPulse(irqPulse), .smiPulse(smiPulse), .resetReq(resetReq),
    .stage(stage), .prevReboot(prevReboot)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG_CYCLES && !done) begin
      fails++;
      $display("FAIL watchdog: run hung, cycles %0d expected below %0d", cycles, WATCHDOG_CYCLES);
      report();
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic writePreload(input logic sel, input logic [19:0] val);
    preloadWr = 1'b1; preloadSel = sel; preloadData = val;
    @(negedge clk);
    preloadWr = 1'b0;
  endtask

  task automatic blockReset();
    enable = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic clearFlag();
    flagClear = 1'b1;
    @(negedge clk);
    flagClear = 1'b0;
  endtask

  function automatic int scaled(input logic [19:0] p, input logic fast);
    return fast ? (int'(p) << 5) : (int'(p) << 15);
  endfunction

  task automatic runVector(input vec_t v);
    int n, m, stray;
    n = scaled(v.pre1, v.fast);
    m = scaled(v.pre2, v.fast);
    stray = 0;
    blockReset();
    clearFlag();
    writePreload(1'b0, v.pre1);
    writePreload(1'b1, v.pre2);
    fastScale = v.fast; intType = v.itype; rebootEn = v.reboot; freeRun = v.free;
    enable = 1'b1;
    @(negedge clk);
    // k = 0 corresponds to the edge that started stage one
    for (int k = 0; k <= n + m + 2; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 0) begin
        check(stage == 2'd1, "R3 start stage", int'(stage), 1);
      end else if (k == n + 1) begin
        check(stage == 2'd2, "R2 stage-one expiry timing", int'(stage), 2);
        check(irqPulse == (v.itype == 2'd0), "R5 irq kind", int'(irqPulse), int'(v.itype == 2'd0));
        check(smiPulse == (v.itype == 2'd2), "R5 smi kind", int'(smiPulse), int'(v.itype == 2'd2));
      end else if (k == n + m + 2) begin
        check(resetReq == v.reboot, "R6 reset request", int'(resetReq), int'(v.reboot));
        check(prevReboot == v.reboot, "R6 sticky flag", int'(prevReboot), int'(v.reboot));
        check(int'(stage) == ((!v.reboot && v.free) ? 1 : 0), "R7 stage after stage two",
              int'(stage), (!v.reboot && v.free) ? 1 : 0);
      end else begin
        if (irqPulse || smiPulse || resetReq) stray++;
        if (k <= n && stage != 2'd1) stray++;
        if (k > n + 1 && stage != 2'd2) stray++;
      end
    end
    check(stray == 0, "R2 no early or stray events", stray, 0);
  endtask

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    porRst_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    check(stage == 2'd0, "R1 stage idle", int'(stage), 0);
    check({irqPulse, smiPulse, resetReq} == 3'b000, "R1 pulses low",
          int'({irqPulse, smiPulse, resetReq}), 0);
    check(prevReboot == 1'b0, "R1 flag low", int'(prevReboot), 0);

    // R4 reload while disarmed is ignored
    reload = 1'b1; @(negedge clk); reload = 1'b0;
    @(negedge clk);
    check(stage == 2'd0, "R4 reload while disabled", int'(stage), 0);

    for (int i = 0; i < NUM_VECS; i++) runVector(VECS[i]);

    // R4 reload restarts stage one; R9 mid-stage write has no effect on current stage
    blockReset();
    writePreload(1'b0, 20'd4);
    writePreload(1'b1, 20'd20);
    fastScale = 1'b1; intType = 2'd0; rebootEn = 1'b0; freeRun = 1'b0;
    enable = 1'b1;
    @(negedge clk);
    repeat (10) @(negedge clk);
    writePreload(1'b0, 20'd1);          // R9: not used until next load
    repeat (108) @(negedge clk);        // now 119 edges into a 128-tick stage
    check(stage == 2'd1, "R9 mid-stage write ignored", int'(stage), 1);
    repeat (10) @(negedge clk);         // edge 129
    check(irqPulse == 1'b1, "R9 old preload timing kept", int'(irqPulse), 1);
    check(stage == 2'd2, "R5 enters stage two", int'(stage), 2);
    repeat (5) @(negedge clk);
    reload = 1'b1; @(negedge clk); reload = 1'b0;   // reload edge R; new preload 1 -> N=32
    check(stage == 2'd1, "R4 reload back to stage one", int'(stage), 1);
    repeat (32) @(negedge clk);         // edge R+32: still counting
    check(irqPulse == 1'b0 && stage == 2'd1, "R4 no early expiry after reload", int'(stage), 1);
    @(negedge clk);                     // edge R+33
    check(irqPulse == 1'b1, "R4 expiry N+1 after reload", int'(irqPulse), 1);

    // R3 dropping enable stops the count
    enable = 1'b0;
    @(negedge clk);
    check(stage == 2'd0, "R3 disable stops", int'(stage), 0);
    begin
      int seen = 0;
      repeat (200) begin
        @(negedge clk);
        if (irqPulse || smiPulse || resetReq || stage != 2'd0) seen++;
      end
      check(seen == 0, "R3 stays idle while low", seen, 0);
    end

    // R6 disarm and restore after a watchdog reset
    blockReset();
    clearFlag();
    writePreload(1'b0, 20'd0);
    writePreload(1'b1, 20'd0);
    rebootEn = 1'b1; freeRun = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check(resetReq == 1'b1, "R6 zero preload reset at edge 2", int'(resetReq), 1);
    reload = 1'b1; @(negedge clk); reload = 1'b0;
    repeat (5) @(negedge clk);
    check(stage == 2'd0, "R6 disarmed, reload and held enable ignored", int'(stage), 0);
    enable = 1'b0; @(negedge clk);
    enable = 1'b1; @(negedge clk);
    begin
      int early = 0;
      repeat (300) begin
        @(negedge clk);
        if (irqPulse || stage != 2'd1) early++;
      end
      check(early == 0, "R6 preloads restored to 0xFFFFF", early, 0);
    end

    // R8 flag survives block reset, cleared by flagClear
    blockReset();
    check(prevReboot == 1'b1, "R8 flag kept over rst_n", int'(prevReboot), 1);
    clearFlag();
    check(prevReboot == 1'b0, "R8 flag cleared", int'(prevReboot), 0);

    report();
  end

endmodule